// File: doc/BRIEF.md
# Source and destination operand decoder with constant generation

This block turns the addressing fields of a 16-bit two-operand or single-operand instruction into an operand access request for the execute stage. For the source operand, it reads a 2-bit mode and a 4-bit register number. It then reports one of three kinds of operand: use the register value, access memory at a computed address, or use an immediate constant. Two registers take on special duties. Register 3 always produces a constant. Register 2 produces either a constant or an absolute address, depending on the mode. The program counter (register 0) gives PC-relative and immediate forms.

The caller supplies several inputs: the instruction word, a flag that marks single-operand formats, the program counter (pointing at the first extension word), the values of the selected source and destination registers, and the two extension words that may follow the instruction. One cycle after `in_valid`, the block returns a registered decode. That decode holds the source kind, address and constant, any auto-increment request on the source register, the destination access, and the program counter advanced past every extension word that was consumed. When `in_valid` is low, the outputs keep their last decode.

Top module: `opnd_decode`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: The source register is instruction bits 11:8 when `single_op` is 0, and bits 3:0 when `single_op` is 1. The source mode is bits 5:4.
- R3: For source registers 1 and 4 to 15, the modes behave as follows. Mode 0 gives kind 0 (register). Mode 1 gives kind 1 (memory) at `src_val + src_ext` and requests an extension word. Mode 2 gives kind 1 at `src_val`. When the kind is not memory, `src_addr` is 0. When the kind is not 2 (constant), `src_const` is 0.
- R4: Mode 3 on registers 1 and 4 to 15 gives kind 1 at `src_val`. It also raises `inc_req` with `inc_reg` equal to the source register, and `inc_step` is 1 when bit 6 is set (byte) and 2 otherwise. In every other case, `inc_req`, `inc_reg` and `inc_step` are 0.
- R5: Source register 3 gives kind 2 with constants 0, 1, 2 and all-ones for modes 0 to 3, and never requests an extension word.
- R6: Source register 2 behaves by mode. Mode 0 gives kind 0. Mode 1 gives kind 1 at `src_ext` (absolute) with an extension request. Mode 2 gives constant 4. Mode 3 gives constant 8.
- R7: Source register 0 behaves by mode. Mode 0 gives kind 0. Mode 1 gives kind 1 at `pc + src_ext` with an extension request. Mode 2 gives kind 1 at `pc`. Mode 3 gives kind 2 with constant `src_ext` and an extension request.
- R8: `pc_next` equals `pc` plus 2 for each extension request (source and destination) of the same decode.
- R9: When `single_op` is 1 or instruction bit 7 is 0, `dst_mem`, `dst_ext_req` and `dst_addr` are 0.
- R10: When `single_op` is 0 and bit 7 is 1, `dst_mem` and `dst_ext_req` are 1. The destination register (bits 3:0) then sets `dst_addr` as follows. Register 2 gives `dst_ext`. Register 0 gives `pc + dst_ext`, plus 2 more when the source took an extension word. Any other register gives `dst_val + dst_ext`.
- R11: `out_valid` is `in_valid` delayed one cycle. In a cycle with `in_valid` low, no decode output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode the presented instruction this cycle |
| instr | input | 16 | Instruction word |
| single_op | input | 1 | Instruction is a single-operand format |
| pc | input | W | Address of the first extension word |
| src_val | input | W | Value of the selected source register |
| dst_val | input | W | Value of the destination register |
| src_ext | input | W | Extension word for the source |
| dst_ext | input | W | Extension word for the destination |
| out_valid | output | 1 | Decode below is fresh |
| src_kind | output | 2 | 0 register, 1 memory, 2 constant |
| src_addr | output | W | Source memory address |
| src_const | output | W | Source constant or immediate |
| src_ext_req | output | 1 | Source consumed an extension word |
| inc_req | output | 1 | Increment the source register after access |
| inc_reg | output | 4 | Register to increment |
| inc_step | output | 2 | Increment amount |
| dst_mem | output | 1 | Destination is in memory |
| dst_ext_req | output | 1 | Destination consumed an extension word |
| dst_addr | output | W | Destination memory address |
| pc_next | output | W | Program counter past consumed extension words |

## Verification
The assertions assume that the decode fields are only meaningful one cycle after `in_valid`. They also assume that `pc` and the extension words are stable values presented together with the instruction. The bench keeps to this by changing every input once per cycle, on the falling edge. A reference model computes each expected decode from the inputs sampled at that edge. Directed vectors cover each mode for registers 0, 2 and 3. They also cover byte and word auto-increment, and the PC-relative destination that follows a source extension word. Random words then mix every field, with `in_valid` sometimes low to exercise the hold behaviour.

// File: rtl/opnd_decode.sv
module opnd_decode #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [15:0]  instr,
  input  logic         single_op,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] src_val,
  input  logic [W-1:0] dst_val,
  input  logic [W-1:0] src_ext,
  input  logic [W-1:0] dst_ext,
  output logic         out_valid,
  output logic [1:0]   src_kind,
  output logic [W-1:0] src_addr,
  output logic [W-1:0] src_const,
  output logic         src_ext_req,
  output logic         inc_req,
  output logic [3:0]   inc_reg,
  output logic [1:0]   inc_step,
  output logic         dst_mem,
  output logic         dst_ext_req,
  output logic [W-1:0] dst_addr,
  output logic [W-1:0] pc_next
);
  localparam logic [1:0] K_REG = 2'd0, K_MEM = 2'd1, K_CON = 2'd2;
  localparam logic [3:0] PC_R = 4'd0, SR_R = 4'd2, CG_R = 4'd3;
  localparam logic [W-1:0] C1 = W'(1), C2 = W'(2), C4 = W'(4), C8 = W'(8);

  logic [3:0]   sel;
  logic [1:0]   mode;
  logic         dmode;
  logic [1:0]   n_kind;
  logic [W-1:0] n_addr, n_const, n_daddr, n_pc;
  logic         n_sx, n_inc, n_dm;
  logic [1:0]   n_step;

  assign sel   = single_op ? instr[3:0] : instr[11:8];
  assign mode  = instr[5:4];
  assign dmode = instr[7] & ~single_op;

  always_comb begin
    n_kind  = K_REG;
    n_addr  = '0;
    n_const = '0;
    n_sx    = 1'b0;
    n_inc   = 1'b0;
    n_step  = 2'd0;
    if (sel == CG_R) begin
      n_kind = K_CON;
      unique case (mode)
        2'd0: n_const = '0;
        2'd1: n_const = C1;
        2'd2: n_const = C2;
        default: n_const = '1;
      endcase
    end else if (sel == SR_R) begin
      unique case (mode)
        2'd0: n_kind = K_REG;
        2'd1: begin n_kind = K_MEM; n_addr = src_ext; n_sx = 1'b1; end
        2'd2: begin n_kind = K_CON; n_const = C4; end
        default: begin n_kind = K_CON; n_const = C8; end
      endcase
    end else if (sel == PC_R) begin
      unique case (mode)
        2'd0: n_kind = K_REG;
        2'd1: begin n_kind = K_MEM; n_addr = pc + src_ext; n_sx = 1'b1; end
        2'd2: begin n_kind = K_MEM; n_addr = pc; end
        default: begin n_kind = K_CON; n_const = src_ext; n_sx = 1'b1; end
      endcase
    end else begin
      unique case (mode)
        2'd0: n_kind = K_REG;
        2'd1: begin n_kind = K_MEM; n_addr = src_val + src_ext; n_sx = 1'b1; end
        2'd2: begin n_kind = K_MEM; n_addr = src_val; end
        default: begin
          n_kind = K_MEM;
          n_addr = src_val;
          n_inc  = 1'b1;
          n_step = instr[6] ? 2'd1 : 2'd2;
        end
      endcase
    end
  end

  always_comb begin
    n_dm    = dmode;
    n_daddr = '0;
    if (dmode) begin
      if (instr[3:0] == SR_R)      n_daddr = dst_ext;
      else if (instr[3:0] == PC_R) n_daddr = pc + (n_sx ? C2 : '0) + dst_ext;
      else                         n_daddr = dst_val + dst_ext;
    end
    n_pc = pc + (n_sx ? C2 : '0) + (n_dm ? C2 : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      src_kind    <= K_REG;
      src_addr    <= '0;
      src_const   <= '0;
      src_ext_req <= 1'b0;
      inc_req     <= 1'b0;
      inc_reg     <= '0;
      inc_step    <= '0;
      dst_mem     <= 1'b0;
      dst_ext_req <= 1'b0;
      dst_addr    <= '0;
      pc_next     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        src_kind    <= n_kind;
        src_addr    <= n_addr;
        src_const   <= n_const;
        src_ext_req <= n_sx;
        inc_req     <= n_inc;
        inc_reg     <= n_inc ? sel : 4'd0;
        inc_step    <= n_step;
        dst_mem     <= n_dm;
        dst_ext_req <= n_dm;
        dst_addr    <= n_daddr;
        pc_next     <= n_pc;
      end
    end
  end
endmodule

module opnd_decode_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [15:0]  instr,
  input logic         single_op,
  input logic [W-1:0] pc,
  input logic         out_valid,
  input logic [1:0]   src_kind,
  input logic [W-1:0] src_addr,
  input logic         src_ext_req,
  input logic         inc_req,
  input logic         dst_mem,
  input logic         dst_ext_req,
  input logic [W-1:0] pc_next
);
  logic [3:0] sel_in;
  assign sel_in = single_op ? instr[3:0] : instr[11:8];

  // R5
  cg_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_in == 4'd3) |=> (src_kind == 2'd2 && !src_ext_req && !inc_req));

  // R4
  inc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[5:4] != 2'd3) |=> !inc_req);

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> pc_next == $past(pc) + W'(2 * (32'(src_ext_req) + 32'(dst_ext_req))));

  // R9
  dst_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (single_op || !instr[7])) |=> (!dst_mem && !dst_ext_req));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(src_addr) && $stable(pc_next) && $stable(src_kind)));
endmodule

bind opnd_decode opnd_decode_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
  .single_op(single_op), .pc(pc), .out_valid(out_valid),
  .src_kind(src_kind), .src_addr(src_addr), .src_ext_req(src_ext_req),
  .inc_req(inc_req), .dst_mem(dst_mem), .dst_ext_req(dst_ext_req),
  .pc_next(pc_next)
);

// File: tb/sim_opnd_decode.sv
module sim_opnd_decode;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, single_op = 1'b0;
  logic [15:0] instr = '0;
  logic [W-1:0] pc = '0, src_val = '0, dst_val = '0, src_ext = '0, dst_ext = '0;
  logic out_valid, src_ext_req, inc_req, dst_mem, dst_ext_req;
  logic [1:0] src_kind, inc_step;
  logic [3:0] inc_reg;
  logic [W-1:0] src_addr, src_const, dst_addr, pc_next;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;

  int e_kind, e_addr, e_const, e_sx, e_inc, e_ireg, e_step, e_dm, e_daddr, e_pc, e_ov;
  string t_src, t_dst;

  always #10 clk = ~clk;

  opnd_decode #(.W(W)) u0 (.*);

  task automatic cmp(string tag, string f, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, f, act, exp);
    end
  endtask

  task automatic model();
    int sr, m, dr, p;
    p  = int'(pc);
    sr = single_op ? int'(instr[3:0]) : int'(instr[11:8]);
    m  = int'(instr[5:4]);
    e_ov = in_valid;
    if (!in_valid) begin t_src = "R11"; t_dst = "R11"; return; end
    e_kind = 0; e_addr = 0; e_const = 0; e_sx = 0; e_inc = 0; e_ireg = 0; e_step = 0;
    if (sr == 3) begin
      t_src = "R5"; e_kind = 2;
      e_const = (m == 3) ? 'hFFFF : m;
    end else if (sr == 2) begin
      t_src = "R6";
      if (m == 1) begin e_kind = 1; e_addr = src_ext; e_sx = 1; end
      else if (m == 2) begin e_kind = 2; e_const = 4; end
      else if (m == 3) begin e_kind = 2; e_const = 8; end
    end else if (sr == 0) begin
      t_src = "R7";
      if (m == 1) begin e_kind = 1; e_addr = (p + src_ext) & 'hFFFF; e_sx = 1; end
      else if (m == 2) begin e_kind = 1; e_addr = p; end
      else if (m == 3) begin e_kind = 2; e_const = src_ext; e_sx = 1; end
    end else begin
      t_src = single_op ? "R2" : "R3";
      if (m == 1) begin e_kind = 1; e_addr = (src_val + src_ext) & 'hFFFF; e_sx = 1; end
      else if (m == 2) begin e_kind = 1; e_addr = src_val; end
      else if (m == 3) begin
        t_src = "R4"; e_kind = 1; e_addr = src_val; e_inc = 1; e_ireg = sr;
        e_step = instr[6] ? 1 : 2;
      end
    end
    e_dm = (!single_op && instr[7]) ? 1 : 0;
    e_daddr = 0;
    dr = int'(instr[3:0]);
    if (e_dm == 1) begin
      t_dst = "R10";
      if (dr == 2) e_daddr = dst_ext;
      else if (dr == 0) e_daddr = (p + 2 * e_sx + dst_ext) & 'hFFFF;
      else e_daddr = (dst_val + dst_ext) & 'hFFFF;
    end else t_dst = "R9";
    e_pc = (p + 2 * (e_sx + e_dm)) & 'hFFFF;
  endtask

  task automatic check_all();
    cmp("R11", "out_valid", out_valid, e_ov);
    cmp(t_src, "src_kind", src_kind, e_kind);
    cmp(t_src, "src_addr", src_addr, e_addr);
    cmp(t_src, "src_const", src_const, e_const);
    cmp(t_src, "src_ext_req", src_ext_req, e_sx);
    cmp(t_src, "inc_req", inc_req, e_inc);
    cmp(t_src, "inc_reg", inc_reg, e_ireg);
    cmp(t_src, "inc_step", inc_step, e_step);
    cmp(t_dst, "dst_mem", dst_mem, e_dm);
    cmp(t_dst, "dst_ext_req", dst_ext_req, e_dm);
    cmp(t_dst, "dst_addr", dst_addr, e_daddr);
    cmp("R8", "pc_next", pc_next, e_pc);
  endtask

  task automatic step(logic v, logic [15:0] ins, logic so, int p, int sv, int dv, int se, int de);
    in_valid = v; instr = ins; single_op = so; pc = W'(p);
    src_val = W'(sv); dst_val = W'(dv); src_ext = W'(se); dst_ext = W'(de);
    model();
    @(negedge clk);
    check_all();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    e_kind = 0; e_addr = 0; e_const = 0; e_sx = 0; e_inc = 0; e_ireg = 0;
    e_step = 0; e_dm = 0; e_daddr = 0; e_pc = 0; e_ov = 0;
    t_src = "R1"; t_dst = "R1";
    in_valid = 1'b1; instr = 16'hFFFF; pc = 16'h1234;
    repeat (3) @(negedge clk);
    check_all(); // R1: all zero under reset
    rst_n = 1'b1;
    // R5 constant generator, all modes
    for (int m = 0; m < 4; m++) step(1, 16'h0300 | 16'(m << 4), 0, 'h100, 'h55, 0, 'h77, 0);
    // R6 status register modes
    for (int m = 0; m < 4; m++) step(1, 16'h0200 | 16'(m << 4), 0, 'h100, 'h55, 0, 'h4000, 0);
    // R7 PC modes
    for (int m = 0; m < 4; m++) step(1, 16'h0000 | 16'(m << 4), 0, 'h100, 'h55, 0, 'h20, 0);
    // R3 general modes 0..2, R4 byte and word auto-increment
    for (int m = 0; m < 4; m++) step(1, 16'h0500 | 16'(m << 4), 0, 'h100, 'h800, 0, 'h10, 0);
    step(1, 16'h0570, 0, 'h100, 'h801, 0, 0, 0);
    // R2 single-operand field select
    step(1, 16'h0F36, 1, 'h100, 'h900, 0, 0, 0);
    step(1, 16'h0316, 1, 'h100, 'h900, 0, 'h4, 0);
    // R10 destination: R2 absolute, PC after source ext, general indexed
    step(1, 16'h4592, 0, 'h200, 'h10, 'h0, 'h8, 'h300);
    step(1, 16'h4090, 0, 'h200, 'h10, 'h0, 'h8, 'h30);
    step(1, 16'h4380, 0, 'h200, 'h10, 'h0, 'h8, 'h30);
    step(1, 16'h4587, 0, 'hFFFE, 'h10, 'hFFF0, 'h8, 'h20);
    // R9 destination register, R11 hold
    step(1, 16'h4507, 0, 'h200, 'h10, 'h0, 'h8, 'h30);
    step(0, 16'h3FB5, 0, 'h999, 'h11, 'h22, 'h33, 'h44);
    for (int i = 0; i < 3000; i++)
      step(($urandom % 5) != 0, 16'($urandom), 1'($urandom), int'($urandom & 'hFFFF),
           int'($urandom & 'hFFFF), int'($urandom & 'hFFFF),
           int'($urandom & 'hFFFF), int'($urandom & 'hFFFF));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule